// File: doc/BRIEF.md
# Byte-Serial Instruction Length Decoder

This block takes a stream of machine-code bytes for a 16-bit variable-length instruction encoding, one byte per accepted handshake, and cuts it into whole instructions. Each instruction comes out as a single record. The record carries the opcode, the fields of the operand-form byte when there is one, the displacement, the immediate and the total byte count, which runs from 1 to 6. A fetch unit feeds bytes at whatever rate it can. Decode logic further down the pipe gets one record per instruction and never has to count bytes itself.

The supported subset has two classes. The first is the single-byte register push, opcodes 0x50 to 0x57, where the low three opcode bits name the register. The second is the immediate-arithmetic group at opcode 0x81. It carries an operand-form byte, an optional displacement and a 16-bit immediate. Any other first byte is reported as unsupported in a one-byte record, and the next byte is decoded as a fresh opcode.

The decoder is a byte-serial state machine. The opcode class selects whether a form byte follows. The mode and r/m fields of that byte then decide how many displacement bytes come before the two immediate bytes.

Top module: `insn_len_dec`

## Requirements
- R1: While reset is asserted, out_valid and in_ready are 0. in_ready is 1 from the first cycle after reset is released, and stays 1.
- R2: A first byte in the range 0x50 to 0x57 produces a record with length 1 and out_push=1. out_rm holds opcode bits 2:0, which is the register index (0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI). out_has_form, out_disp and out_imm are 0.
- R3: After opcode 0x81, the next byte is the operand-form byte. The record reports out_has_form=1, out_mode = bits 7:6, out_ext = bits 5:3 (the sub-operation, 7 meaning compare) and out_rm = bits 2:0.
- R4: The number of displacement bytes after the form byte depends on mode and r/m. Mode 01 gives 1 byte and mode 10 gives 2 bytes. Mode 11 gives none. Mode 00 gives none, except r/m=110, which is a direct address with 2 bytes.
- R5: A 1-byte displacement is reported sign-extended to 16 bits. A 2-byte displacement is assembled little-endian, low byte first. With no displacement, out_disp is 0.
- R6: Two immediate bytes follow the form byte and any displacement, and are reported little-endian as out_imm. For example, 81 FA CD AB gives out_imm=0xABCD.
- R7: A group-0x81 record has out_len = 4 plus the displacement byte count. Every record has 1 <= out_len <= 6.
- R8: Any other first byte produces a 1-byte record with out_unsup=1 and out_push=0. The following byte is treated as a new opcode.
- R9: Bytes offered while in_valid=0 are ignored, and gaps between bytes do not change any record. Exactly one record is produced per instruction, and out_valid stays low in any cycle not preceded by an accepted final byte.
- R10: out_valid is 1 for exactly the one cycle after the clock edge that accepts an instruction's final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered on in_byte |
| in_byte | input | 8 | Machine-code byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | Record fields below are valid this cycle |
| out_opcode | output | 8 | First byte of the instruction |
| out_push | output | 1 | Record is a single-byte register push |
| out_unsup | output | 1 | First byte is outside the supported subset |
| out_has_form | output | 1 | Instruction carries an operand-form byte |
| out_mode | output | 2 | Mode field of the form byte |
| out_ext | output | 3 | Opcode-extension field of the form byte |
| out_rm | output | 3 | r/m field, or push register index |
| out_disp | output | 16 | Displacement, sign-extended if 1 byte |
| out_imm | output | 16 | 16-bit immediate |
| out_len | output | 3 | Instruction length in bytes |

## Verification
The bench targets the mode-00/r/m-110 direct form. A decoder that missed it would emit a 4-byte record and misread the two address bytes as the immediate, which then throws every later instruction boundary off. Negative 8-bit displacements such as 0xF0 catch a missing sign extension. Long stalls with junk bytes on the bus catch a decoder that samples in_byte without in_valid. Unsupported opcodes placed directly before a push or a group opcode show whether decoding realigns after a single byte rather than swallowing the next one.

// File: rtl/ild_pkg.sv
package ild_pkg;

   localparam int unsigned ILD_OCTET_W = 8;
   localparam int unsigned ILD_MAX_LEN = 6;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_FORM,
      ST_DLO,
      ST_DHI,
      ST_ILO,
      ST_IHI
   } ild_state_e;

   typedef enum logic [1:0] {
      CL_PUSH,
      CL_GRP,
      CL_UNSUP
   } ild_class_e;

   typedef struct packed {
      logic [1:0] mode;
      logic [2:0] ext;
      logic [2:0] rm;
   } ild_form_t;

endpackage

// File: rtl/ild_opclass.sv
module ild_opclass
   import ild_pkg::*;
#(
   parameter int unsigned      BYTE_W    = ILD_OCTET_W,
   parameter logic [BYTE_W-1:0] PUSH_BASE = 8'h50,
   parameter logic [BYTE_W-1:0] GRP_OPC   = 8'h81
) (
   input  logic [BYTE_W-1:0] opc,
   output ild_class_e        cls
);

   localparam int unsigned REG_SEL_W = 3;

   logic is_push;
   logic is_grp;

   // push family occupies an aligned run of eight codes
   assign is_push = (opc[BYTE_W-1:REG_SEL_W] == PUSH_BASE[BYTE_W-1:REG_SEL_W]);
   assign is_grp  = (opc == GRP_OPC);

   always_comb begin
      if (is_push)     cls = CL_PUSH;
      else if (is_grp) cls = CL_GRP;
      else             cls = CL_UNSUP;
   end

endmodule

// File: rtl/ild_form_dec.sv
module ild_form_dec
   import ild_pkg::*;
#(
   parameter int unsigned BYTE_W    = ILD_OCTET_W,
   parameter logic [2:0]  DIRECT_RM = 3'b110
) (
   input  logic [BYTE_W-1:0] form_byte,
   output ild_form_t         form,
   output logic [1:0]        disp_cnt
);

   assign form.mode = form_byte[7:6];
   assign form.ext  = form_byte[5:3];
   assign form.rm   = form_byte[2:0];

   always_comb begin
      unique case (form.mode)
         2'b00:   disp_cnt = (form.rm == DIRECT_RM) ? 2'd2 : 2'd0;
         2'b01:   disp_cnt = 2'd1;
         2'b10:   disp_cnt = 2'd2;
         default: disp_cnt = 2'd0;
      endcase
   end

endmodule

// File: rtl/ild_disp_ext.sv
module ild_disp_ext #(
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned WORD_W     = 2 * BYTE_W,
   parameter bit          SEXT_DISP8 = 1'b1
) (
   input  logic [BYTE_W-1:0] lo,
   output logic [WORD_W-1:0] wide
);

   localparam int unsigned PAD_W = WORD_W - BYTE_W;

   if (SEXT_DISP8) begin : g_sext
      assign wide = {{PAD_W{lo[BYTE_W-1]}}, lo};
   end else begin : g_zext
      assign wide = {{PAD_W{1'b0}}, lo};
   end

endmodule

// File: rtl/insn_len_dec.sv
module insn_len_dec
   import ild_pkg::*;
#(
   parameter int unsigned       BYTE_W     = ILD_OCTET_W,
   parameter int unsigned       MAX_LEN    = ILD_MAX_LEN,
   parameter logic [BYTE_W-1:0] PUSH_BASE  = 8'h50,
   parameter logic [BYTE_W-1:0] GRP_OPC    = 8'h81,
   parameter logic [2:0]        DIRECT_RM  = 3'b110,
   parameter bit                SEXT_DISP8 = 1'b1,
   localparam int unsigned      WORD_W     = 2 * BYTE_W,
   localparam int unsigned      LEN_W      = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              in_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_opcode,
   output logic              out_push,
   output logic              out_unsup,
   output logic              out_has_form,
   output logic [1:0]        out_mode,
   output logic [2:0]        out_ext,
   output logic [2:0]        out_rm,
   output logic [WORD_W-1:0] out_disp,
   output logic [WORD_W-1:0] out_imm,
   output logic [LEN_W-1:0]  out_len
);

   localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
   localparam logic [LEN_W-1:0] LEN_FORM = LEN_W'(2);

   // elaboration-time parameter checks
   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("insn_len_dec: BYTE_W must be 8");
   end
   if (MAX_LEN < 6) begin : g_bad_max_len
      $error("insn_len_dec: MAX_LEN must cover 6-byte instructions");
   end
   if (PUSH_BASE[2:0] != 3'b000) begin : g_bad_push_base
      $error("insn_len_dec: PUSH_BASE must be aligned to 8");
   end

   ild_state_e          state_q;
   logic                rdy_q;
   logic [BYTE_W-1:0]   opc_q;
   ild_form_t           form_q;
   logic [1:0]          dcnt_q;
   logic [WORD_W-1:0]   disp_q;
   logic [BYTE_W-1:0]   imm_lo_q;
   logic [LEN_W-1:0]    len_q;

   ild_class_e          cls_w;
   ild_form_t           form_w;
   logic [1:0]          dcnt_w;
   logic [WORD_W-1:0]   dext_w;
   logic                fire;

   assign in_ready = rdy_q;
   assign fire     = in_valid & rdy_q;

   ild_opclass #(
      .BYTE_W    (BYTE_W),
      .PUSH_BASE (PUSH_BASE),
      .GRP_OPC   (GRP_OPC)
   ) u_opclass (
      .opc (in_byte),
      .cls (cls_w)
   );

   ild_form_dec #(
      .BYTE_W    (BYTE_W),
      .DIRECT_RM (DIRECT_RM)
   ) u_form_dec (
      .form_byte (in_byte),
      .form      (form_w),
      .disp_cnt  (dcnt_w)
   );

   ild_disp_ext #(
      .BYTE_W     (BYTE_W),
      .WORD_W     (WORD_W),
      .SEXT_DISP8 (SEXT_DISP8)
   ) u_disp_ext (
      .lo   (in_byte),
      .wide (dext_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_OPC;
         rdy_q        <= 1'b0;
         opc_q        <= '0;
         form_q       <= '0;
         dcnt_q       <= '0;
         disp_q       <= '0;
         imm_lo_q     <= '0;
         len_q        <= '0;
         out_valid    <= 1'b0;
         out_opcode   <= '0;
         out_push     <= 1'b0;
         out_unsup    <= 1'b0;
         out_has_form <= 1'b0;
         out_mode     <= '0;
         out_ext      <= '0;
         out_rm       <= '0;
         out_disp     <= '0;
         out_imm      <= '0;
         out_len      <= '0;
      end else begin
         rdy_q     <= 1'b1;
         out_valid <= 1'b0;
         if (fire) begin
            unique case (state_q)
               ST_OPC: begin
                  opc_q  <= in_byte;
                  len_q  <= LEN_ONE;
                  disp_q <= '0;
                  if (cls_w == CL_GRP) begin
                     state_q <= ST_FORM;
                  end else begin
                     out_valid    <= 1'b1;
                     out_opcode   <= in_byte;
                     out_push     <= (cls_w == CL_PUSH);
                     out_unsup    <= (cls_w == CL_UNSUP);
                     out_has_form <= 1'b0;
                     out_mode     <= '0;
                     out_ext      <= '0;
                     out_rm       <= (cls_w == CL_PUSH) ? in_byte[2:0] : 3'b000;
                     out_disp     <= '0;
                     out_imm      <= '0;
                     out_len      <= LEN_ONE;
                  end
               end
               ST_FORM: begin
                  form_q  <= form_w;
                  dcnt_q  <= dcnt_w;
                  len_q   <= LEN_FORM;
                  state_q <= (dcnt_w != 2'd0) ? ST_DLO : ST_ILO;
               end
               ST_DLO: begin
                  disp_q  <= dext_w;
                  len_q   <= len_q + LEN_ONE;
                  state_q <= (dcnt_q == 2'd2) ? ST_DHI : ST_ILO;
               end
               ST_DHI: begin
                  disp_q[WORD_W-1:BYTE_W] <= in_byte;
                  len_q   <= len_q + LEN_ONE;
                  state_q <= ST_ILO;
               end
               ST_ILO: begin
                  imm_lo_q <= in_byte;
                  len_q    <= len_q + LEN_ONE;
                  state_q  <= ST_IHI;
               end
               ST_IHI: begin
                  out_valid    <= 1'b1;
                  out_opcode   <= opc_q;
                  out_push     <= 1'b0;
                  out_unsup    <= 1'b0;
                  out_has_form <= 1'b1;
                  out_mode     <= form_q.mode;
                  out_ext      <= form_q.ext;
                  out_rm       <= form_q.rm;
                  out_disp     <= disp_q;
                  out_imm      <= {in_byte, imm_lo_q};
                  out_len      <= len_q + LEN_ONE;
                  state_q      <= ST_OPC;
               end
               default: state_q <= ST_OPC;
            endcase
         end
      end
   end

   // ---------------------------------------------------------------
   // assertions
   // ---------------------------------------------------------------
   logic [LEN_W-1:0] chk_grp_len;
   always_comb begin
      if (out_mode == 2'b01)                               chk_grp_len = LEN_W'(5);
      else if (out_mode == 2'b10)                          chk_grp_len = LEN_W'(6);
      else if (out_mode == 2'b00 && out_rm == DIRECT_RM)   chk_grp_len = LEN_W'(6);
      else                                                 chk_grp_len = LEN_W'(4);
   end

   AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> in_ready) else $error("in_ready low after reset"); // R1

   AST_PUSH_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_push) |-> (out_len == LEN_ONE && !out_has_form && !out_unsup))
      else $error("push record malformed"); // R2

   AST_GRP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_has_form) |-> (out_len == chk_grp_len))
      else $error("group length disagrees with form fields"); // R4

   AST_DISP8_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (SEXT_DISP8 && out_valid && out_has_form && out_mode == 2'b01)
         |-> (out_disp[WORD_W-1:BYTE_W] == {BYTE_W{out_disp[BYTE_W-1]}}))
      else $error("8-bit displacement not sign-extended"); // R5

   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len >= LEN_ONE && out_len <= LEN_W'(MAX_LEN)))
      else $error("length out of range"); // R7

   AST_UNSUP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_unsup) |-> (out_len == LEN_ONE && !out_push))
      else $error("unsupported record malformed"); // R8

   AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (state_q == ST_OPC))
      else $error("record emitted mid-instruction"); // R8

   AST_NO_EMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> !out_valid)
      else $error("record without accepted byte"); // R9

endmodule

// File: tb/insn_len_dec_tb_top.sv
module insn_len_dec_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid;
   logic [7:0]  in_byte;
   logic        in_ready;
   logic        out_valid;
   logic [7:0]  out_opcode;
   logic        out_push;
   logic        out_unsup;
   logic        out_has_form;
   logic [1:0]  out_mode;
   logic [2:0]  out_ext;
   logic [2:0]  out_rm;
   logic [15:0] out_disp;
   logic [15:0] out_imm;
   logic [2:0]  out_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   insn_len_dec dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .in_ready     (in_ready),
      .out_valid    (out_valid),
      .out_opcode   (out_opcode),
      .out_push     (out_push),
      .out_unsup    (out_unsup),
      .out_has_form (out_has_form),
      .out_mode     (out_mode),
      .out_ext      (out_ext),
      .out_rm       (out_rm),
      .out_disp     (out_disp),
      .out_imm      (out_imm),
      .out_len      (out_len)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   byte unsigned stream[$];
   byte unsigned cur[$];
   int unsigned  lfsr = 32'h1ACE_B00C;

   // expected record for the coming cycle
   bit        exp_v;
   int        exp_opc, exp_push, exp_unsup, exp_form, exp_mode, exp_ext, exp_rm;
   int        exp_disp, exp_imm, exp_len;
   string     exp_tag;
   int        need;

   function int unsigned nxt();
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hA300_0001 : 32'h0);
      return lfsr;
   endfunction

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic int disp_bytes(input int fb);
      int m = (fb >> 6) & 3;
      int r = fb & 7;
      if (m == 1) return 1;
      if (m == 2) return 2;
      if (m == 0 && r == 6) return 2;
      return 0;
   endfunction

   // behavioural reference: consumes one accepted byte
   task automatic model_byte(input byte unsigned b);
      int dn;
      cur.push_back(b);
      exp_v = 0;
      if (cur.size() == 1) begin
         if (b >= 8'h50 && b <= 8'h57) begin
            exp_v = 1; exp_tag = "R2"; exp_opc = b; exp_push = 1; exp_unsup = 0;
            exp_form = 0; exp_mode = 0; exp_ext = 0; exp_rm = b & 7;
            exp_disp = 0; exp_imm = 0; exp_len = 1;
            cur.delete();
         end else if (b != 8'h81) begin
            exp_v = 1; exp_tag = "R8"; exp_opc = b; exp_push = 0; exp_unsup = 1;
            exp_form = 0; exp_mode = 0; exp_ext = 0; exp_rm = 0;
            exp_disp = 0; exp_imm = 0; exp_len = 1;
            cur.delete();
         end else begin
            need = 99;
         end
      end else begin
         if (cur.size() == 2) need = 4 + disp_bytes(cur[1]);
         if (cur.size() == need) begin
            dn = need - 4;
            exp_v = 1; exp_tag = "R3"; exp_opc = cur[0]; exp_push = 0; exp_unsup = 0;
            exp_form = 1; exp_mode = (cur[1] >> 6) & 3; exp_ext = (cur[1] >> 3) & 7;
            exp_rm = cur[1] & 7;
            if (dn == 1)      exp_disp = (cur[2] >= 128) ? (32'hFF00 | cur[2]) : cur[2];
            else if (dn == 2) exp_disp = cur[2] | (cur[3] << 8);
            else              exp_disp = 0;
            exp_imm = cur[2+dn] | (cur[3+dn] << 8);
            exp_len = need;
            cur.delete();
         end
      end
   endtask

   task automatic compare();
      chk("R9 R10 out_valid timing", out_valid, exp_v);
      if (exp_v && out_valid) begin
         chk({exp_tag, " opcode"},   out_opcode,   exp_opc);
         chk("R2 push flag",         out_push,     exp_push);
         chk("R8 unsupported flag",  out_unsup,    exp_unsup);
         chk("R3 has_form",          out_has_form, exp_form);
         chk("R3 mode field",        out_mode,     exp_mode);
         chk("R3 ext field",         out_ext,      exp_ext);
         chk({exp_tag, " rm field"}, out_rm,       exp_rm);
         chk("R5 displacement",      out_disp,     exp_disp);
         chk("R6 immediate",         out_imm,      exp_imm);
         chk("R4 R7 length",         out_len,      exp_len);
      end
   endtask

   task automatic run_stream(input int gap_pct);
      bit fire;
      while (stream.size() > 0) begin
         @(negedge clk);
         compare();
         if ((nxt() % 100) >= gap_pct) begin
            in_valid = 1'b1;
            in_byte  = stream[0];
         end else begin
            in_valid = 1'b0;
            in_byte  = 8'(nxt());     // junk while idle, must be ignored (R9)
         end
         fire = in_valid && in_ready;
         if (fire) model_byte(stream.pop_front());
         else      exp_v = 0;
      end
      @(negedge clk);
      compare();
      in_valid = 1'b0;
      exp_v    = 0;
      @(negedge clk);
      compare();
   endtask

   task automatic push_list(input byte unsigned b[]);
      foreach (b[i]) stream.push_back(b[i]);
   endtask

   task automatic load_directed();
      push_list('{8'h81, 8'hFA, 8'hCD, 8'hAB});                 // CMP reg, R6
      push_list('{8'h81, 8'h7E, 8'h08, 8'hCD, 8'hAB});          // disp8, R4
      for (int r = 0; r < 8; r++) stream.push_back(8'(8'h50 + r)); // R2
      push_list('{8'h90});                                      // R8
      push_list('{8'h81, 8'h3E, 8'h34, 8'h12, 8'h78, 8'h56});   // direct, R4
      push_list('{8'h81, 8'hBE, 8'h00, 8'h80, 8'h11, 8'h22});   // disp16
      push_list('{8'h81, 8'h07, 8'hEF, 8'hBE});                 // mode00 no disp
      push_list('{8'h81, 8'h46, 8'hF0, 8'h01, 8'h02});          // negative disp8, R5
      push_list('{8'h58, 8'h50, 8'hFF, 8'h81, 8'hC0, 8'hFF, 8'hFF}); // R8 realign
      push_list('{8'h80, 8'h4F, 8'h81, 8'h86, 8'h34, 8'h12, 8'hAA, 8'h55});
   endtask

   task automatic load_random(input int n);
      for (int i = 0; i < n; i++) begin
         int kind = nxt() % 4;
         if (kind == 0) begin
            stream.push_back(8'(8'h50 + (nxt() % 8)));
         end else if (kind == 1) begin
            byte unsigned b = 8'(nxt());
            if ((b >= 8'h50 && b <= 8'h57) || b == 8'h81) b = 8'hC3;
            stream.push_back(b);
         end else begin
            byte unsigned fb = 8'(nxt());
            int dn = disp_bytes(fb);
            stream.push_back(8'h81);
            stream.push_back(fb);
            for (int k = 0; k < dn + 2; k++) stream.push_back(8'(nxt()));
         end
      end
   endtask

   initial begin
      in_valid = 1'b0;
      in_byte  = 8'h00;
      exp_v    = 0;
      need     = 0;
      repeat (3) @(negedge clk);
      chk("R1 out_valid during reset", out_valid, 0);
      chk("R1 in_ready during reset",  in_ready,  0);
      in_byte = 8'h50;                 // offered without valid during reset
      @(negedge clk);
      rst_n   = 1'b1;
      in_byte = 8'h00;
      @(negedge clk);
      chk("R1 in_ready after reset",  in_ready,  1);
      chk("R1 out_valid after reset", out_valid, 0);

      load_directed();  run_stream(0);
      load_directed();  run_stream(45);
      load_random(400); run_stream(30);
      load_random(400); run_stream(0);

      chk("R1 in_ready held high", in_ready, 1);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule